// File: doc/BRIEF.md
# Interval Timer Tick Skip Counter

This block sits between a shared periodic timer tick and four processors. It decides, for each processor, whether a given tick should raise that processor's interval-timer interrupt. Every processor has a software-loaded 24-bit down-counter. Each rising edge of the tick decrements all four counters by one. When a counter has gone below zero, a sticky overflow flag stays set. From that tick on, every tick raises the processor's timer interrupt.

The counter keeps running after overflow. Software can therefore read back how many ticks went by without an interrupt. Writing a counter reloads the 24-bit count and clears the flag. The tick input is asynchronous. It is synchronized and edge-detected inside the block.

The CSR side offers 8-byte-wide writes and registered reads at four fixed offsets. Each tick that fires for a processor produces a one-cycle request. A neighbouring control register uses that request to set the processor's pending bit, numbered 4 plus the processor index, and to signal its interrupt.

Top module: `itick_filter`

## Requirements
- R1: After reset, every slot reads 0: count zero and overflow flag clear. No fire request is active.
- R2: A write to a slot stores bits 23:0 of the write data as the count and clears the overflow flag. Bits 63:24 of the write data are ignored.
- R3: On each counted tick, the 25-bit value {flag, count} of every slot not being written decrements by one modulo 2^25. A flag that was already set stays set.
- R4: Once set, the overflow flag is cleared only by a write to that slot, and further ticks leave it set.
- R5: Only a rising edge of `tick_in` counts as a tick. Holding the input high for many cycles gives exactly one decrement, and a falling edge gives none.
- R6: `fire[i]` pulses for exactly one cycle for each counted tick after which slot i's flag is set. It stays low for ticks that leave the flag clear.
- R7: The slots sit at byte offsets 0x380 (slot 0), 0x3C0 (slot 1), 0x700 (slot 2) and 0x740 (slot 3). A read returns the flag in bit 24 and the count in bits 23:0, with zeros above. Any other offset reads 0, and writes to other offsets change no slot.
- R8: When a write to a slot lands in the same cycle as a counted tick, the write wins for that slot. That slot neither decrements nor fires on this tick, while the other slots still decrement.
- R9: `csr_rvalid` rises one cycle after `csr_re` is sampled high, and `csr_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Asynchronous periodic timer tick level |
| csr_we | input | 1 | Write strobe |
| csr_re | input | 1 | Read strobe |
| csr_addr | input | 12 | Byte offset of the access |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, valid with csr_rvalid |
| csr_rvalid | output | 1 | Read data valid, one cycle after csr_re |
| fire | output | 4 | Per-processor one-cycle timer interrupt request, also sets pending bit 4+i |

## Verification
The hardest case to reach is a software write that lands in exactly the cycle in which the synchronized tick edge is consumed. From the ports, that cycle is hidden behind the synchronizer stages. The stimulus raises `tick_in` on a falling clock edge and counts the known synchronizer and edge-detect delay. It then asserts the write strobe for the one cycle in which the internal tick pulse is live. The write then has to win in that slot while the other slots decrement.

Sticky overflow with a continued count is reached by letting counters wrap through zero over several ticks. The bench compares read-back values and accumulated fire counts at every step.

// File: rtl/itick_pkg.sv
package itick_pkg;

  localparam int unsigned SLOT_MAX   = 4;
  localparam int unsigned CSR_AW     = 12;
  localparam int unsigned CSR_DW     = 64;

  // Fixed byte offset of each processor's counter slot.
  function automatic logic [CSR_AW-1:0] slot_offset(input int unsigned idx);
    case (idx)
      0:       slot_offset = 12'h380;
      1:       slot_offset = 12'h3C0;
      2:       slot_offset = 12'h700;
      default: slot_offset = 12'h740;
    endcase
  endfunction

endpackage

// File: rtl/itick_sync.sv
module itick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_pulse = sync_q[STAGES-1] & ~last_q;

  // R5: an edge event lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/itick_slot.sv
module itick_slot #(
  parameter int unsigned CNT_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic           tick,
  output logic [CNT_W:0] value,
  output logic           fire
);

  localparam int unsigned VAL_W = CNT_W + 1;

  logic [VAL_W-1:0] val_q;
  logic [VAL_W-1:0] val_d;
  logic [VAL_W-1:0] dec_val;
  logic             val_en;
  logic             fire_q;
  logic             fire_d;

  always_comb begin
    dec_val        = val_q - VAL_W'(1);
    dec_val[CNT_W] = dec_val[CNT_W] | val_q[CNT_W];
    val_en         = wr_en | tick;
    fire_d         = 1'b0;
    if (wr_en) begin
      val_d = {1'b0, wr_cnt};
    end else begin
      val_d  = dec_val;
      fire_d = tick & dec_val[CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
    end else begin
      fire_q <= fire_d;
    end
  end

  assign value = val_q;
  assign fire  = fire_q;

  // R2: a write leaves the flag clear
  a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !value[CNT_W]);
  // R4: the flag stays set without a write
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (value[CNT_W] && !wr_en) |=> value[CNT_W]);
  // R3: a tick without a write steps the count down by one
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> (value[CNT_W-1:0] == $past(value[CNT_W-1:0]) - CNT_W'(1)));
  // R6: a fire request only appears with the flag set
  a_r6_fire_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> value[CNT_W]);
  // R8: a write beats a simultaneous tick
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wr_en) |=> (!fire && value[CNT_W-1:0] == $past(wr_cnt)));

endmodule

// File: rtl/itick_filter.sv
module itick_filter #(
  parameter int unsigned N_SLOT = 4,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned SYNC_N = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_in,
  input  logic        csr_we,
  input  logic        csr_re,
  input  logic [11:0] csr_addr,
  input  logic [63:0] csr_wdata,
  output logic [63:0] csr_rdata,
  output logic        csr_rvalid,
  output logic [N_SLOT-1:0] fire
);

  import itick_pkg::*;

  localparam int unsigned VAL_W = CNT_W + 1;

  initial begin
    if (N_SLOT > SLOT_MAX || N_SLOT == 0) $error("N_SLOT out of range");
    if (VAL_W > CSR_DW) $error("CNT_W too wide");
  end

  logic              tick_p;
  logic [N_SLOT-1:0] hit;
  logic [N_SLOT-1:0] wr_hit;
  logic [VAL_W-1:0]  slot_val [N_SLOT];
  logic [CSR_DW-1:0] rd_d;
  logic [CSR_DW-1:0] rd_q;
  logic              rv_q;

  itick_sync #(.STAGES(SYNC_N)) sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (tick_in),
    .rise_pulse (tick_p)
  );

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    assign hit[g]    = (csr_addr == slot_offset(g));
    assign wr_hit[g] = csr_we & hit[g];

    itick_slot #(.CNT_W(CNT_W)) slot_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_hit[g]),
      .wr_cnt (csr_wdata[CNT_W-1:0]),
      .tick   (tick_p),
      .value  (slot_val[g]),
      .fire   (fire[g])
    );
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (hit[i]) rd_d = CSR_DW'(slot_val[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      rv_q <= csr_re;
      if (csr_re) rd_q <= rd_d;
    end
  end

  assign csr_rdata  = rd_q;
  assign csr_rvalid = rv_q;

  // R9: read data follows the strobe by one cycle
  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    csr_re |=> csr_rvalid);
  // R7: reads of unmapped offsets return zero
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_re && hit == '0) |=> (csr_rdata == '0));
  // R7: upper read bits are always zero
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rvalid |-> (csr_rdata[CSR_DW-1:VAL_W] == '0));

endmodule

// File: tb/itick_filter_tb_top.sv
module itick_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_in;
  logic        csr_we;
  logic        csr_re;
  logic [11:0] csr_addr;
  logic [63:0] csr_wdata;
  logic [63:0] csr_rdata;
  logic        csr_rvalid;
  logic [3:0]  fire;

  int total = 0;
  int bad   = 0;
  int fire_cnt [4];
  logic [63:0] exp_q [$];
  string       tag_q [$];

  localparam logic [11:0] OFS [4] = '{12'h380, 12'h3C0, 12'h700, 12'h740};

  always #4 clk = ~clk;

  itick_filter dut_i (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .csr_we(csr_we), .csr_re(csr_re),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_rvalid(csr_rvalid), .fire(fire)
  );

  // monitor: pops expected reads and counts fire pulses
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++) if (fire[i]) fire_cnt[i]++;
      if (csr_rvalid) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R9 unexpected read data act=%h exp=none", csr_rdata);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (csr_rdata !== e) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", t, csr_rdata, e);
          end
        end
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [63:0] e, input string t);
    @(negedge clk);
    csr_re = 1'b1; csr_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    csr_re = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic tick(input int high_cycles);
    @(negedge clk);
    tick_in = 1'b1;
    repeat (high_cycles) @(negedge clk);
    tick_in = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic read_all(input logic [63:0] e0, e1, e2, e3, input string t);
    rd(OFS[0], e0, {t, " slot0"});
    rd(OFS[1], e1, {t, " slot1"});
    rd(OFS[2], e2, {t, " slot2"});
    rd(OFS[3], e3, {t, " slot3"});
  endtask

  task automatic chk_fire(input int e0, e1, e2, e3, input string t);
    int e [4];
    e = '{e0, e1, e2, e3};
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      total++;
      if (fire_cnt[i] != e[i]) begin
        bad++;
        $display("FAIL %s fire count slot%0d act=%0d exp=%0d", t, i, fire_cnt[i], e[i]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) fire_cnt[i] = 0;
    rst_n = 1'b0; tick_in = 1'b0; csr_we = 1'b0; csr_re = 1'b0;
    csr_addr = '0; csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R7 offsets
    read_all(64'h0, 64'h0, 64'h0, 64'h0, "R1 reset");
    chk_fire(0, 0, 0, 0, "R1 no fire after reset");

    // first tick wraps zero: flag set, fires everywhere (R3, R6)
    tick(2);
    read_all(64'h1FF_FFFF, 64'h1FF_FFFF, 64'h1FF_FFFF, 64'h1FF_FFFF, "R3 wrap from zero");
    chk_fire(1, 1, 1, 1, "R6 first tick");

    // R2 writes: low 24 bits kept, flag cleared, upper bits dropped
    wr(OFS[0], 64'd5);
    wr(OFS[1], 64'd0);
    wr(OFS[2], 64'hFFFF_FFFF_FF12_3456);
    read_all(64'd5, 64'd0, 64'h12_3456, 64'h1FF_FFFF, "R2 write");

    // R3/R4/R6 one tick
    tick(2);
    read_all(64'd4, 64'h1FF_FFFF, 64'h12_3455, 64'h1FF_FFFE, "R4 tick1");
    chk_fire(1, 2, 1, 2, "R6 tick1");

    // R5 long high level is one tick
    tick(40);
    read_all(64'd3, 64'h1FF_FFFE, 64'h12_3454, 64'h1FF_FFFD, "R5 long level");
    chk_fire(1, 3, 1, 3, "R5 long level");

    // four ticks: slot0 passes zero on the last (R3, R6)
    for (int k = 0; k < 4; k++) tick(2);
    read_all(64'h1FF_FFFF, 64'h1FF_FFFA, 64'h12_3450, 64'h1FF_FFF9, "R3 four ticks");
    chk_fire(2, 7, 1, 7, "R6 four ticks");

    // R8 write lands in the tick pulse cycle for slot0
    @(negedge clk);
    tick_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = OFS[0]; csr_wdata = 64'd100;
    @(negedge clk);
    csr_we = 1'b0;
    repeat (4) @(negedge clk);
    tick_in = 1'b0;
    repeat (8) @(negedge clk);
    read_all(64'd100, 64'h1FF_FFF9, 64'h12_344F, 64'h1FF_FFF8, "R8 collision");
    chk_fire(2, 8, 1, 8, "R8 collision");

    // R4 write clears a set flag
    wr(OFS[1], 64'd1);
    rd(OFS[1], 64'd1, "R4 flag cleared by write");
    tick(2);
    read_all(64'd99, 64'd0, 64'h12_344E, 64'h1FF_FFF7, "R4 after clear");
    chk_fire(2, 8, 1, 9, "R6 after clear");

    // R7 unmapped offsets
    wr(12'h384, 64'hFFFF);
    wr(12'h000, 64'h1234);
    rd(12'h384, 64'h0, "R7 unmapped read");
    rd(12'h000, 64'h0, "R7 unmapped read zero");
    read_all(64'd99, 64'd0, 64'h12_344E, 64'h1FF_FFF7, "R7 unmapped write ignored");

    repeat (4) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R9 reads missing act=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule